// File: doc/BRIEF.md
# Infrared Pulse Run-Length Encoder

This block turns the raw output of an infrared receiver into a stream of run-length entries. The asynchronous receiver line first passes through a two-stage synchroniser. An optional polarity inversion follows. The line is then sampled once per sample tick, and a tick comes every `DIV` module clock cycles (64 by default). Consecutive samples of the same level are counted. When the level changes, the run that just ended is emitted as a single byte: the top bit holds the level and the low seven bits hold the run length minus one.

Short disturbances are filtered out by sample count. A level change is accepted only after it has lasted for the programmed noise threshold. A shorter excursion is counted as part of the run around it. Runs that would not fit in seven bits are split. A long non-pulse stretch closes the packet: the block flushes the pending run, pulses a packet-end strobe, and then stays silent until the next pulse. A downstream FIFO and a protocol decoder consume the entries. Neither is part of this block.

Top module: `irRunEncoder`

## Requirements
- R1: The line is sampled once every `DIV` clock cycles, counted from the cycle the receiver becomes enabled. Each sample period yields at most one entry, and `entryValid` is never high on two consecutive cycles.
- R2: Each entry is a byte. Bit 7 holds the run level after optional inversion (1 = pulse). Bits 6:0 hold the run length in sample periods minus one.
- R3: A run that reaches 128 samples emits an entry with count 127. Counting of the same level then continues from zero, and the remainder appears in a later entry.
- R4: When `polarityInv` is 1 the input is complemented before any other processing. The entries are then the ones the complemented line would give.
- R5: A new level is accepted only once it has lasted `noiseThr` consecutive samples. A value of 0 acts like 1. A shorter excursion emits nothing, and its samples are added to the surrounding run.
- R6: When the line is at level 0 and the low run (glitch samples included) exceeds `idleThr` samples, the block emits the pending low run with `packetEnd` high. That entry's count is clipped to 127. The block then emits nothing until an accepted level-1 run begins.
- R7: No entry is produced unless both `globalEn` and `rxEn` are 1.
- R8: Dropping either enable discards the run in progress and clears all counters. After re-enabling, the line is treated as idle.
- R9: `packetEnd` is high only together with `entryValid`, and only for a level-0 entry.
- R10: While reset is held, `entryValid`, `packetEnd` and `entryData` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Asynchronous active-low reset |
| globalEn | input | 1 | Block-level enable |
| rxEn | input | 1 | Receive enable; low clears all counters |
| polarityInv | input | 1 | Complement the receiver line |
| noiseThr | input | 6 | Minimum samples for a level change to be accepted |
| idleThr | input | 8 | Low samples after which the packet is closed |
| irIn | input | 1 | Asynchronous receiver line |
| entryValid | output | 1 | One-cycle strobe: entryData holds a new entry |
| entryData | output | 8 | Level bit 7, run length minus one in bits 6:0 |
| packetEnd | output | 1 | Marks the entry that closes a packet |

## Verification
Directed patterns come first. Short alternating runs exercise the basic byte format. A 130-sample pulse followed by a 135-sample gap separates correct splitting and remainder carry from wraparound or truncation. Sub-threshold excursions, including one placed in the middle of the idle tail, show whether glitches are merged or wrongly emitted. A zero noise threshold is also run. Seeded random run lengths with varying thresholds are run with and without inversion. One random pattern is cut off mid-run by dropping `rxEn`, which exposes any state that leaks into the next enable. A pattern driven with `globalEn` low must yield no entries at all.

// File: rtl/irRlePkg.sv
package irRlePkg;

  // Strobes the control side hands to the run datapath each cycle
  typedef struct packed {
    logic clear;   // receiver disabled: drop all run state
    logic tick;    // one sample period has elapsed
    logic level;   // synchronised, polarity-corrected line value
  } rleStrobe_t;

endpackage

// File: rtl/irRleFrontEnd.sv
module irRleFrontEnd
  import irRlePkg::*;
#(
  parameter int DIV         = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       globalEn,
  input  logic       rxEn,
  input  logic       polarityInv,
  input  logic       irIn,
  output rleStrobe_t strobe
);

  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [DIV_W-1:0]       divCnt;
  logic                   active;
  logic                   divWrap;

  // synchroniser chain for the asynchronous line
  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[0] <= 1'b0;
        else       syncQ[0] <= irIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[i] <= 1'b0;
        else       syncQ[i] <= syncQ[i-1];
      end
    end
  end

  assign active  = globalEn & rxEn;
  assign divWrap = (divCnt == DIV_LAST);

  // sample prescaler, restarts from zero on every enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        divCnt <= '0;
    else if (!active) divCnt <= '0;
    else if (divWrap) divCnt <= '0;
    else              divCnt <= divCnt + DIV_W'(1);
  end

  always_comb begin
    strobe.clear = ~active;
    strobe.tick  = active & divWrap;
    strobe.level = syncQ[SYNC_STAGES-1] ^ polarityInv;
  end

endmodule

// File: rtl/irRleDatapath.sv
module irRleDatapath
  import irRlePkg::*;
#(
  parameter int CNT_W   = 7,
  parameter int NOISE_W = 6,
  parameter int IDLE_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  rleStrobe_t         strobe,
  input  logic [NOISE_W-1:0] noiseThr,
  input  logic [IDLE_W-1:0]  idleThr,
  output logic               entryValid,
  output logic [CNT_W:0]     entryData,
  output logic               packetEnd
);

  localparam int ACC_W   = ((CNT_W > NOISE_W) ? CNT_W : NOISE_W) + 2;
  localparam int ISUM_W  = ((IDLE_W > NOISE_W) ? IDLE_W : NOISE_W) + 2;
  localparam int CAND_W  = NOISE_W + 1;
  localparam logic [ACC_W-1:0]  RUN_MAX  = ACC_W'(2 ** CNT_W);
  localparam logic [ISUM_W-1:0] IDLE_SAT = ISUM_W'((2 ** IDLE_W) - 1);

  // run state
  logic               curLevel, curLevelN;
  logic [ACC_W-1:0]   runCnt, runCntN;
  logic [NOISE_W-1:0] candCnt, candCntN;
  logic [IDLE_W-1:0]  idleRun, idleRunN;
  logic               idleMode, idleModeN;
  logic               validN, peN;
  logic [CNT_W:0]     dataN;

  // working values
  logic [ACC_W-1:0]   total;
  logic [CAND_W-1:0]  candNew, thrEff;
  logic [ISUM_W-1:0]  idleSumRaw;
  logic [IDLE_W-1:0]  idleSum;
  logic [CNT_W-1:0]   clipLen, runLen;

  always_comb begin
    total      = runCnt + ACC_W'(candCnt) + ACC_W'(1);
    candNew    = CAND_W'(candCnt) + CAND_W'(1);
    thrEff     = (noiseThr == '0) ? CAND_W'(1) : CAND_W'(noiseThr);
    idleSumRaw = ISUM_W'(idleRun) + ISUM_W'(candCnt) + ISUM_W'(1);
    idleSum    = (idleSumRaw > IDLE_SAT) ? IDLE_SAT[IDLE_W-1:0] : idleSumRaw[IDLE_W-1:0];
    clipLen    = (total >= RUN_MAX) ? {CNT_W{1'b1}} : CNT_W'(total - ACC_W'(1));
    runLen     = CNT_W'(runCnt - ACC_W'(1));
  end

  always_comb begin
    curLevelN = curLevel;
    runCntN   = runCnt;
    candCntN  = candCnt;
    idleRunN  = idleRun;
    idleModeN = idleMode;
    validN    = 1'b0;
    peN       = 1'b0;
    dataN     = '0;
    if (strobe.clear) begin
      curLevelN = 1'b0;
      runCntN   = '0;
      candCntN  = '0;
      idleRunN  = '0;
      idleModeN = 1'b1;
    end else if (strobe.tick) begin
      if (strobe.level == curLevel) begin
        // level held: any pending excursion becomes part of this run
        candCntN = '0;
        if (!idleMode) begin
          if (!curLevel && (idleSum > idleThr)) begin
            validN    = 1'b1;
            peN       = 1'b1;
            dataN     = {1'b0, clipLen};
            runCntN   = '0;
            idleRunN  = '0;
            idleModeN = 1'b1;
          end else if (total >= RUN_MAX) begin
            validN   = 1'b1;
            dataN    = {curLevel, {CNT_W{1'b1}}};
            runCntN  = total - RUN_MAX;
            idleRunN = curLevel ? '0 : idleSum;
          end else begin
            runCntN  = total;
            idleRunN = curLevel ? '0 : idleSum;
          end
        end
      end else if (candNew >= thrEff) begin
        // new level has lasted long enough: close the old run
        if (runCnt != '0) begin
          validN = 1'b1;
          dataN  = {curLevel, runLen};
        end
        curLevelN = strobe.level;
        runCntN   = ACC_W'(candNew);
        candCntN  = '0;
        idleRunN  = strobe.level ? '0 : IDLE_W'(candNew);
        idleModeN = 1'b0;
      end else begin
        candCntN = candNew[NOISE_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curLevel   <= 1'b0;
      runCnt     <= '0;
      candCnt    <= '0;
      idleRun    <= '0;
      idleMode   <= 1'b1;
      entryValid <= 1'b0;
      entryData  <= '0;
      packetEnd  <= 1'b0;
    end else begin
      curLevel   <= curLevelN;
      runCnt     <= runCntN;
      candCnt    <= candCntN;
      idleRun    <= idleRunN;
      idleMode   <= idleModeN;
      entryValid <= validN;
      entryData  <= dataN;
      packetEnd  <= peN;
    end
  end

endmodule

// File: rtl/irRunEncoder.sv
module irRunEncoder
  import irRlePkg::*;
#(
  parameter int DIV         = 64,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 7,
  parameter int NOISE_W     = 6,
  parameter int IDLE_W      = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               globalEn,
  input  logic               rxEn,
  input  logic               polarityInv,
  input  logic [NOISE_W-1:0] noiseThr,
  input  logic [IDLE_W-1:0]  idleThr,
  input  logic               irIn,
  output logic               entryValid,
  output logic [CNT_W:0]     entryData,
  output logic               packetEnd
);

  rleStrobe_t strobe;

  irRleFrontEnd #(
    .DIV        (DIV),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_front (
    .clk        (clk),
    .rstN       (rstN),
    .globalEn   (globalEn),
    .rxEn       (rxEn),
    .polarityInv(polarityInv),
    .irIn       (irIn),
    .strobe     (strobe)
  );

  irRleDatapath #(
    .CNT_W  (CNT_W),
    .NOISE_W(NOISE_W),
    .IDLE_W (IDLE_W)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .noiseThr  (noiseThr),
    .idleThr   (idleThr),
    .entryValid(entryValid),
    .entryData (entryData),
    .packetEnd (packetEnd)
  );

endmodule

// File: rtl/irRunEncoderChecker.sv
module irRunEncoderChecker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          globalEn,
  input logic          rxEn,
  input logic          entryValid,
  input logic [DW-1:0] entryData,
  input logic          packetEnd
);

  // set by a packet end, cleared by the next entry or by disabling
  logic afterPe;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 afterPe <= 1'b0;
    else if (!(globalEn & rxEn)) afterPe <= 1'b0;
    else if (entryValid)       afterPe <= packetEnd;
  end

  p_entry_single_r1: assert property (@(posedge clk) disable iff (!rstN)
    entryValid |=> !entryValid);

  p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(globalEn && rxEn) |=> !entryValid);

  p_pe_needs_entry_r9: assert property (@(posedge clk) disable iff (!rstN)
    packetEnd |-> entryValid);

  p_pe_low_level_r9: assert property (@(posedge clk) disable iff (!rstN)
    packetEnd |-> !entryData[DW-1]);

  p_wake_on_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    (afterPe && entryValid) |-> entryData[DW-1]);

endmodule

bind irRunEncoder irRunEncoderChecker #(.DW(CNT_W + 1)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .globalEn  (globalEn),
  .rxEn      (rxEn),
  .entryValid(entryValid),
  .entryData (entryData),
  .packetEnd (packetEnd)
);

// File: tb/irRunEncoder_bench.sv
module irRunEncoder_bench;

  localparam int DIV = 64;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       globalEn = 1'b0;
  logic       rxEn = 1'b0;
  logic       polarityInv = 1'b0;
  logic [5:0] noiseThr = '0;
  logic [7:0] idleThr = '0;
  logic       irIn = 1'b0;
  logic       entryValid;
  logic [7:0] entryData;
  logic       packetEnd;

  int nChecks = 0;
  int nFails  = 0;
  int expQ[$];
  int gotQ[$];
  bit monOn = 1'b0;

  // reference state
  bit mCur, mIdleMode;
  int mRun, mCand, mIdleRun, mNoise, mIdle;

  always #5 clk = ~clk;

  irRunEncoder u_irRunEncoder (
    .clk(clk), .rstN(rstN), .globalEn(globalEn), .rxEn(rxEn),
    .polarityInv(polarityInv), .noiseThr(noiseThr), .idleThr(idleThr),
    .irIn(irIn), .entryValid(entryValid), .entryData(entryData),
    .packetEnd(packetEnd)
  );

  always @(negedge clk)
    if (monOn && entryValid) gotQ.push_back({23'd0, packetEnd, entryData});

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int mkEntry(input bit pe, input bit lvl, input int len);
    return (pe ? 256 : 0) | (lvl ? 128 : 0) | (len - 1);
  endfunction

  // expected behaviour of one sample period, from R2 R3 R5 R6
  task automatic modelTick(input bit s);
    int total, candNew, idleSum, thr;
    thr = (mNoise == 0) ? 1 : mNoise;
    if (s == mCur) begin
      total = mRun + mCand + 1;
      idleSum = mIdleRun + mCand + 1;
      if (idleSum > 255) idleSum = 255;
      mCand = 0;
      if (!mIdleMode) begin
        if (!mCur && idleSum > mIdle) begin
          expQ.push_back(mkEntry(1'b1, 1'b0, (total >= 128) ? 128 : total));
          mIdleMode = 1'b1; mRun = 0; mIdleRun = 0;
        end else if (total >= 128) begin
          expQ.push_back(mkEntry(1'b0, mCur, 128));
          mRun = total - 128; mIdleRun = mCur ? 0 : idleSum;
        end else begin
          mRun = total; mIdleRun = mCur ? 0 : idleSum;
        end
      end
    end else begin
      candNew = mCand + 1;
      if (candNew >= thr) begin
        if (mRun > 0) expQ.push_back(mkEntry(1'b0, mCur, mRun));
        mCur = s; mRun = candNew; mCand = 0;
        mIdleRun = s ? 0 : candNew; mIdleMode = 1'b0;
      end else mCand = candNew;
    end
  endtask

  task automatic driveSample(input bit v, input bit modelOn);
    @(negedge clk);
    irIn = v ^ polarityInv;
    if (modelOn) modelTick(v);
    repeat (DIV) @(posedge clk);
  endtask

  task automatic driveRun(input bit v, input int len, input bit modelOn = 1'b1);
    for (int i = 0; i < len; i++) driveSample(v, modelOn);
  endtask

  task automatic startScen(input int nz, input int idl, input bit inv, input bit gEn);
    @(negedge clk);
    noiseThr = 6'(nz); idleThr = 8'(idl); polarityInv = inv;
    irIn = inv; globalEn = gEn; rxEn = 1'b1;
    mCur = 1'b0; mIdleMode = 1'b1; mRun = 0; mCand = 0; mIdleRun = 0;
    mNoise = nz; mIdle = idl;
    expQ.delete(); gotQ.delete(); monOn = 1'b1;
    repeat (DIV/2 - 1) @(posedge clk);
  endtask

  task automatic endScen(input string req);
    repeat (4) @(negedge clk);
    rxEn = 1'b0;
    repeat (4) @(negedge clk);
    monOn = 1'b0;
    check(gotQ.size() == expQ.size(), {req, " entry count"}, gotQ.size(), expQ.size());
    for (int i = 0; i < expQ.size() && i < gotQ.size(); i++)
      check(gotQ[i] == expQ[i], {req, " entry"}, gotQ[i], expQ[i]);
  endtask

  task automatic randRuns(input int n);
    for (int k = 0; k < n; k++)
      driveRun(k[0] ? 1'b0 : 1'b1, 1 + int'($urandom_range(0, 11)));
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin : main
    int seedDummy;
    seedDummy = $urandom(32'd2024);
    // R10 reset state
    repeat (3) @(negedge clk);
    check(!entryValid && !packetEnd && entryData == 8'h00, "R10 reset outputs",
          {entryValid, packetEnd, entryData}, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R2 R1 basic short runs, closed by idle (R6)
    startScen(1, 20, 1'b0, 1'b1);
    driveRun(1, 5); driveRun(0, 3); driveRun(1, 1); driveRun(0, 10); driveRun(1, 2);
    driveRun(0, 30);
    endScen("R2 R1 R6 basic");

    // R3 saturation of long runs, remainder carried
    startScen(1, 140, 1'b0, 1'b1);
    driveRun(1, 130); driveRun(0, 135); driveRun(1, 3); driveRun(0, 143);
    endScen("R3 saturation");

    // R5 glitch merge, including glitch inside idle tail (R6)
    startScen(4, 12, 1'b0, 1'b1);
    driveRun(1, 2); driveRun(0, 3);
    driveRun(1, 6); driveRun(0, 2); driveRun(1, 5); driveRun(0, 6);
    driveRun(1, 3); driveRun(0, 8); driveRun(1, 3); driveRun(0, 20);
    driveRun(1, 2); driveRun(0, 6);
    endScen("R5 R6 glitch");

    // R5 zero noise threshold acts like one
    startScen(0, 10, 1'b0, 1'b1);
    driveRun(1, 1); driveRun(0, 1); driveRun(1, 4); driveRun(0, 14);
    endScen("R5 zero threshold");

    // R4 inverted input, random runs
    startScen(1 + int'($urandom_range(0, 2)), 25, 1'b1, 1'b1);
    randRuns(20); driveRun(0, 30);
    endScen("R4 inverted");

    // random thresholds, then mid-run disable
    startScen(1 + int'($urandom_range(0, 3)), 10 + int'($urandom_range(0, 20)), 1'b0, 1'b1);
    randRuns(24); driveRun(0, 35);
    endScen("R5 R6 random");
    startScen(2, 15, 1'b0, 1'b1);
    randRuns(15); driveRun(1, 40);
    endScen("R8 cut mid-run");

    // R8 fresh start after the cut: leading low is idle, new runs counted anew
    startScen(1, 15, 1'b0, 1'b1);
    driveRun(0, 4); driveRun(1, 7); driveRun(0, 20);
    endScen("R8 restart");

    // R7 global enable low: nothing emitted
    startScen(1, 10, 1'b0, 1'b0);
    driveRun(1, 6, 1'b0); driveRun(0, 4, 1'b0); driveRun(1, 3, 1'b0); driveRun(0, 15, 1'b0);
    endScen("R7 gated");

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule